// File: doc/BRIEF.md
# Prescaled 64-bit Compare Timer

This block is the counting core of a machine timer. A 64-bit count advances by a programmable step on every tick of a prescaler. It raises an interrupt once the count reaches a 64-bit compare value. Software reaches every register through a plain port per register: a write strobe, write data and read data. There is no bus adapter in front of it. Interrupt delivery goes through a sticky state bit, an enable mask and a test trigger.

The prescaler divides the clock by `prescale + 1`. Each division wrap is one tick, and on a tick the count adds the step value, zero-extended. A write to a compare half raises an update pulse in the following cycle. On that pulse the comparator reloads its working copy of the compare value. Until the first such write the copy holds all-ones, so the block cannot interrupt out of reset.

Top module: `step_timer`

## Requirements
- R1: After reset these values hold: active bit 0, prescale 0, step 1, count 0, both compare halves 0xFFFFFFFF, interrupt enable 0, interrupt state 0, interrupt line low.
- R2: While the active bit is 0 and no count half is written, the count holds its value, and the prescaler restarts from zero.
- R3: While active, a tick occurs every prescale+1 clocks; with prescale 0 the count advances on every clock.
- R4: On a tick the count adds the step value, zero-extended to 64 bits. Both halves change in the same cycle and the sum wraps modulo 2^64.
- R5: A software write to a count half overrides a tick that falls in the same cycle. The written half takes the write data, and the other half keeps its value.
- R6: The configuration word carries prescale in bits 11:0 and step in bits 23:16; bits 15:12 and 31:24 read as zero.
- R7: A write to either compare half updates that register at the write edge and gives an update pulse one clock later. On that pulse the comparator loads the new compare value.
- R8: While count >= the comparator's compare value, the interrupt state is set on the next edge.
- R9: Writing 1 to the state bit clears it and wins over a set in the same cycle. Writing 0 leaves the state unchanged.
- R10: Writing 1 to the test register sets the interrupt state on that edge. The test register always reads 0.
- R11: The interrupt line is high exactly when both the state bit and the enable bit are 1. The state bit records events even while the enable is 0.
- R12: Both count halves and both compare halves read back what software last wrote, until hardware changes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_we | input | 1 | Active-bit write strobe |
| run_wd | input | 1 | Active-bit write data |
| run_rd | output | 1 | Active-bit read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wd | input | 32 | Configuration write data |
| cfg_rd | output | 32 | Configuration read data |
| cnt_lo_we | input | 1 | Count low half write strobe |
| cnt_lo_wd | input | 32 | Count low half write data |
| cnt_lo_rd | output | 32 | Count low half read data |
| cnt_hi_we | input | 1 | Count high half write strobe |
| cnt_hi_wd | input | 32 | Count high half write data |
| cnt_hi_rd | output | 32 | Count high half read data |
| cmp_lo_we | input | 1 | Compare low half write strobe |
| cmp_lo_wd | input | 32 | Compare low half write data |
| cmp_lo_rd | output | 32 | Compare low half read data |
| cmp_hi_we | input | 1 | Compare high half write strobe |
| cmp_hi_wd | input | 32 | Compare high half write data |
| cmp_hi_rd | output | 32 | Compare high half read data |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wd | input | 1 | Interrupt enable write data |
| ien_rd | output | 1 | Interrupt enable read data |
| ist_we | input | 1 | Interrupt state write strobe (write 1 to clear) |
| ist_wd | input | 1 | Interrupt state write data |
| ist_rd | output | 1 | Interrupt state read data |
| itst_we | input | 1 | Interrupt test write strobe |
| itst_wd | input | 1 | Interrupt test write data |
| itst_rd | output | 1 | Interrupt test read data, always 0 |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default widths: a 12-bit prescaler, an 8-bit step and a 64-bit count. Small prescale values put several ticks and prescaler restarts into a short run. Loading the count halves just below all-ones brings the 64-bit carry and the modulo wrap within a few cycles. A step of 0x80 exposes any sign extension. Compare values placed a few ticks ahead of the count show the two-cycle compare reload and the set-versus-clear race on the state bit.

// File: rtl/step_timer_pkg.sv
package step_timer_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned PRESC_LSB = 0;
  localparam int unsigned STEP_LSB  = 16;

  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    logic  we;
    word_t wd;
  } wr_t;

  // interrupt state next value: clear wins over set
  function automatic logic irq_state_next(input logic cur, input logic set, input logic clr);
    if (clr)      return 1'b0;
    else if (set) return 1'b1;
    else          return cur;
  endfunction
endpackage

// File: rtl/step_timer_presc.sv
module step_timer_presc #(
  parameter int unsigned PRESC_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] limit,
  output logic               tick
);
  logic [PRESC_W-1:0] div_q;

  function automatic logic at_limit(input logic [PRESC_W-1:0] d, input logic [PRESC_W-1:0] l);
    return d == l;
  endfunction

  assign tick = run && at_limit(div_q, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (!run)   div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // R3: a tick restarts the divider
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (div_q == '0));
  // R2: idle keeps the divider parked
  a_r2_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (div_q == '0));
endmodule

// File: rtl/step_timer_count.sv
module step_timer_count
  import step_timer_pkg::*;
#(
  parameter int unsigned STEP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [STEP_W-1:0]   step,
  input  wr_t                 lo_wr,
  input  wr_t                 hi_wr,
  output logic [2*DATA_W-1:0] cnt,
  output logic                sw_wr
);
  localparam int unsigned CW = 2 * DATA_W;

  function automatic logic [CW-1:0] advance(input logic [CW-1:0] c, input logic [STEP_W-1:0] s);
    return c + {{(CW-STEP_W){1'b0}}, s};
  endfunction

  word_t          half_q [2];
  logic [CW-1:0]  stepped;
  logic [1:0]     half_we;
  word_t          half_wd [2];

  assign sw_wr      = lo_wr.we | hi_wr.we;
  assign half_we    = {hi_wr.we, lo_wr.we};
  assign half_wd[0] = lo_wr.wd;
  assign half_wd[1] = hi_wr.wd;
  assign cnt        = {half_q[1], half_q[0]};
  assign stepped    = advance(cnt, step);

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           half_q[h] <= '0;
      else if (sw_wr) begin
        if (half_we[h])     half_q[h] <= half_wd[h];
      end
      else if (tick)        half_q[h] <= stepped[h*DATA_W +: DATA_W];
    end
  end

  // R2: no tick and no write keeps the count
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sw_wr) |=> $stable(cnt));
  // R4: a tick adds exactly the zero-extended step
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sw_wr) |=> ((cnt - $past(cnt)) == CW'($past(step))));
  // R5: software write wins, other half untouched
  a_r5_sw_lo: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr.we |=> (cnt[DATA_W-1:0] == $past(lo_wr.wd)));
  a_r5_keep_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr.we && !hi_wr.we) |=> (cnt[CW-1:DATA_W] == $past(cnt[CW-1:DATA_W])));
endmodule

// File: rtl/step_timer_cmp.sv
module step_timer_cmp
  import step_timer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  wr_t                 lo_wr,
  input  wr_t                 hi_wr,
  input  logic [2*DATA_W-1:0] cnt,
  output logic [2*DATA_W-1:0] cmp,
  output logic                upd,
  output logic                evt
);
  localparam int unsigned CW = 2 * DATA_W;

  function automatic logic reached(input logic [CW-1:0] c, input logic [CW-1:0] lim);
    return c >= lim;
  endfunction

  word_t         reg_q [2];
  logic [1:0]    half_we;
  word_t         half_wd [2];
  logic          upd_q;
  logic [CW-1:0] core_q;

  assign half_we    = {hi_wr.we, lo_wr.we};
  assign half_wd[0] = lo_wr.wd;
  assign half_wd[1] = hi_wr.wd;
  assign cmp        = {reg_q[1], reg_q[0]};

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          reg_q[h] <= '1;
      else if (half_we[h]) reg_q[h] <= half_wd[h];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q  <= 1'b0;
      core_q <= '1;
    end else begin
      upd_q <= |half_we;
      if (upd_q) core_q <= cmp;
    end
  end

  assign upd = upd_q;
  assign evt = reached(cnt, core_q);

  // R7: each compare write yields the pulse one clock later
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr.we || hi_wr.we) |=> upd);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_wr.we || hi_wr.we) |=> !upd);
  // R7: the pulse loads the comparator's copy
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (core_q == $past(cmp)));
endmodule

// File: rtl/step_timer_irq.sv
module step_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic en_we,
  input  logic en_wd,
  input  logic st_we,
  input  logic st_wd,
  input  logic tst_we,
  input  logic tst_wd,
  output logic en,
  output logic st,
  output logic irq
);
  import step_timer_pkg::*;

  logic en_q, st_q, set_req, clr_req;

  assign set_req = evt | (tst_we & tst_wd);
  assign clr_req = st_we & st_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      st_q <= 1'b0;
    end else begin
      if (en_we) en_q <= en_wd;
      st_q <= irq_state_next(st_q, set_req, clr_req);
    end
  end

  assign en  = en_q;
  assign st  = st_q;
  assign irq = en_q & st_q;

  // R8: an event sets the state
  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !(st_we && st_wd)) |=> st);
  // R9: writing one clears, writing zero leaves it alone
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_wd) |=> !st);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st && !(st_we && st_wd)) |=> st);
  // R10: test write sets the state
  a_r10_test: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_we && tst_wd && !(st_we && st_wd)) |=> st);
endmodule

// File: rtl/step_timer.sv
module step_timer
  import step_timer_pkg::*;
#(
  parameter int unsigned PRESC_W = 12,
  parameter int unsigned STEP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_we,
  input  logic              run_wd,
  output logic              run_rd,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wd,
  output logic [DATA_W-1:0] cfg_rd,
  input  logic              cnt_lo_we,
  input  logic [DATA_W-1:0] cnt_lo_wd,
  output logic [DATA_W-1:0] cnt_lo_rd,
  input  logic              cnt_hi_we,
  input  logic [DATA_W-1:0] cnt_hi_wd,
  output logic [DATA_W-1:0] cnt_hi_rd,
  input  logic              cmp_lo_we,
  input  logic [DATA_W-1:0] cmp_lo_wd,
  output logic [DATA_W-1:0] cmp_lo_rd,
  input  logic              cmp_hi_we,
  input  logic [DATA_W-1:0] cmp_hi_wd,
  output logic [DATA_W-1:0] cmp_hi_rd,
  input  logic              ien_we,
  input  logic              ien_wd,
  output logic              ien_rd,
  input  logic              ist_we,
  input  logic              ist_wd,
  output logic              ist_rd,
  input  logic              itst_we,
  input  logic              itst_wd,
  output logic              itst_rd,
  output logic              irq_o
);
  localparam int unsigned CW = 2 * DATA_W;
  localparam logic [STEP_W-1:0] STEP_RST = STEP_W'(1);

  function automatic word_t pack_cfg(input logic [PRESC_W-1:0] p, input logic [STEP_W-1:0] s);
    word_t w;
    w = '0;
    w[PRESC_LSB +: PRESC_W] = p;
    w[STEP_LSB  +: STEP_W]  = s;
    return w;
  endfunction

  logic               run_q;
  logic [PRESC_W-1:0] presc_q;
  logic [STEP_W-1:0]  step_q;
  logic               tick;
  logic               sw_cnt_wr;
  logic               cmp_upd;
  logic               cmp_evt;
  logic [CW-1:0]      cnt;
  logic [CW-1:0]      cmp;
  wr_t                cnt_lo_w, cnt_hi_w, cmp_lo_w, cmp_hi_w;
  logic               cfg_unused;

  assign cfg_unused = ^cfg_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      presc_q <= '0;
      step_q  <= STEP_RST;
    end else begin
      if (run_we) run_q <= run_wd;
      if (cfg_we) begin
        presc_q <= cfg_wd[PRESC_LSB +: PRESC_W];
        step_q  <= cfg_wd[STEP_LSB  +: STEP_W];
      end
    end
  end

  assign cnt_lo_w = '{we: cnt_lo_we, wd: cnt_lo_wd};
  assign cnt_hi_w = '{we: cnt_hi_we, wd: cnt_hi_wd};
  assign cmp_lo_w = '{we: cmp_lo_we, wd: cmp_lo_wd};
  assign cmp_hi_w = '{we: cmp_hi_we, wd: cmp_hi_wd};

  step_timer_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .limit (presc_q),
    .tick  (tick)
  );

  step_timer_count #(.STEP_W(STEP_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .step  (step_q),
    .lo_wr (cnt_lo_w),
    .hi_wr (cnt_hi_w),
    .cnt   (cnt),
    .sw_wr (sw_cnt_wr)
  );

  step_timer_cmp u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .lo_wr (cmp_lo_w),
    .hi_wr (cmp_hi_w),
    .cnt   (cnt),
    .cmp   (cmp),
    .upd   (cmp_upd),
    .evt   (cmp_evt)
  );

  step_timer_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (cmp_evt),
    .en_we  (ien_we),
    .en_wd  (ien_wd),
    .st_we  (ist_we),
    .st_wd  (ist_wd),
    .tst_we (itst_we),
    .tst_wd (itst_wd),
    .en     (ien_rd),
    .st     (ist_rd),
    .irq    (irq_o)
  );

  assign run_rd    = run_q;
  assign cfg_rd    = pack_cfg(presc_q, step_q);
  assign cnt_lo_rd = cnt[DATA_W-1:0];
  assign cnt_hi_rd = cnt[CW-1:DATA_W];
  assign cmp_lo_rd = cmp[DATA_W-1:0];
  assign cmp_hi_rd = cmp[CW-1:DATA_W];
  assign itst_rd   = 1'b0;

  // R3: no tick is produced while inactive
  a_r3_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !tick);
  // R5: a count write suppresses the tick's effect on the unwritten half
  a_r5_hi_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hi_we && !cnt_lo_we) |=> (cnt_lo_rd == $past(cnt_lo_rd)));
  // R11: the line never rises without the enable
  a_r11_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_rd |-> !irq_o);
  // R10: the test register reads zero
  a_r10_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    itst_we |=> (itst_rd == 1'b0));
endmodule

// File: tb/step_timer_bench.sv
module step_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        run_we = 0, run_wd = 0, run_rd;
  logic        cfg_we = 0;
  logic [31:0] cfg_wd = 0, cfg_rd;
  logic        cnt_lo_we = 0, cnt_hi_we = 0, cmp_lo_we = 0, cmp_hi_we = 0;
  logic [31:0] cnt_lo_wd = 0, cnt_hi_wd = 0, cmp_lo_wd = 0, cmp_hi_wd = 0;
  logic [31:0] cnt_lo_rd, cnt_hi_rd, cmp_lo_rd, cmp_hi_rd;
  logic        ien_we = 0, ien_wd = 0, ien_rd;
  logic        ist_we = 0, ist_wd = 0, ist_rd;
  logic        itst_we = 0, itst_wd = 0, itst_rd;
  logic        irq_o;

  step_timer u_step_timer (
    .clk(clk), .rst_n(rst_n),
    .run_we(run_we), .run_wd(run_wd), .run_rd(run_rd),
    .cfg_we(cfg_we), .cfg_wd(cfg_wd), .cfg_rd(cfg_rd),
    .cnt_lo_we(cnt_lo_we), .cnt_lo_wd(cnt_lo_wd), .cnt_lo_rd(cnt_lo_rd),
    .cnt_hi_we(cnt_hi_we), .cnt_hi_wd(cnt_hi_wd), .cnt_hi_rd(cnt_hi_rd),
    .cmp_lo_we(cmp_lo_we), .cmp_lo_wd(cmp_lo_wd), .cmp_lo_rd(cmp_lo_rd),
    .cmp_hi_we(cmp_hi_we), .cmp_hi_wd(cmp_hi_wd), .cmp_hi_rd(cmp_hi_rd),
    .ien_we(ien_we), .ien_wd(ien_wd), .ien_rd(ien_rd),
    .ist_we(ist_we), .ist_wd(ist_wd), .ist_rd(ist_rd),
    .itst_we(itst_we), .itst_wd(itst_wd), .itst_rd(itst_rd),
    .irq_o(irq_o)
  );

  // behavioural reference state
  bit              m_run, m_en, m_st, m_upd;
  int              m_div, m_presc, m_step;
  longint unsigned m_cnt, m_cmp, m_core;
  bit              m_tk, m_evt;
  longint unsigned m_cnt_n;

  int    vectors = 0;
  int    misses  = 0;
  string cur_req = "R1";
  bit    live    = 0;
  bit    done    = 0;

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_en = 0; m_st = 0; m_upd = 0;
      m_div = 0; m_presc = 0; m_step = 1;
      m_cnt = 0; m_cmp = '1; m_core = '1;
    end else begin
      m_tk  = m_run && (m_div == m_presc);
      m_evt = (m_cnt >= m_core);
      // state bit: clear beats set
      if (ist_we && ist_wd)                 m_st = 0;
      else if (m_evt || (itst_we && itst_wd)) m_st = 1;
      if (ien_we) m_en = ien_wd;
      // comparator copy loads from the register on the pulse
      if (m_upd) m_core = m_cmp;
      m_upd = cmp_lo_we || cmp_hi_we;
      if (cmp_lo_we) m_cmp = {m_cmp[63:32], cmp_lo_wd};
      if (cmp_hi_we) m_cmp = {cmp_hi_wd, m_cmp[31:0]};
      // count
      m_cnt_n = m_cnt;
      if (cnt_lo_we || cnt_hi_we) begin
        if (cnt_lo_we) m_cnt_n = {m_cnt_n[63:32], cnt_lo_wd};
        if (cnt_hi_we) m_cnt_n = {cnt_hi_wd, m_cnt_n[31:0]};
      end else if (m_tk) begin
        m_cnt_n = m_cnt + longint'(m_step);
      end
      m_cnt = m_cnt_n;
      // prescaler
      if (!m_run)    m_div = 0;
      else if (m_tk) m_div = 0;
      else           m_div = (m_div + 1) % 4096;
      if (run_we) m_run = run_wd;
      if (cfg_we) begin
        m_presc = int'(cfg_wd[11:0]);
        m_step  = int'(cfg_wd[23:16]);
      end
    end
  end

  // per-cycle compare, away from the rising edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk(cur_req, run_rd, m_run);
      chk(cur_req, cfg_rd, {8'h0, 8'(m_step), 4'h0, 12'(m_presc)});
      chk(cur_req, cnt_lo_rd, m_cnt[31:0]);
      chk(cur_req, cnt_hi_rd, m_cnt[63:32]);
      chk(cur_req, cmp_lo_rd, m_cmp[31:0]);
      chk(cur_req, cmp_hi_rd, m_cmp[63:32]);
      chk(cur_req, ien_rd, m_en);
      chk(cur_req, ist_rd, m_st);
      chk(cur_req, itst_rd, 0);
      chk(cur_req, irq_o, m_st && m_en);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic w_run(input logic v);
    @(negedge clk); #1; run_we = 1; run_wd = v;
    @(negedge clk); #1; run_we = 0;
  endtask
  task automatic w_cfg(input logic [31:0] v);
    @(negedge clk); #1; cfg_we = 1; cfg_wd = v;
    @(negedge clk); #1; cfg_we = 0;
  endtask
  task automatic w_cnt(input bit hi, input logic [31:0] v);
    @(negedge clk); #1;
    if (hi) begin cnt_hi_we = 1; cnt_hi_wd = v; end
    else    begin cnt_lo_we = 1; cnt_lo_wd = v; end
    @(negedge clk); #1; cnt_hi_we = 0; cnt_lo_we = 0;
  endtask
  task automatic w_cmp(input bit hi, input logic [31:0] v);
    @(negedge clk); #1;
    if (hi) begin cmp_hi_we = 1; cmp_hi_wd = v; end
    else    begin cmp_lo_we = 1; cmp_lo_wd = v; end
    @(negedge clk); #1; cmp_hi_we = 0; cmp_lo_we = 0;
  endtask
  task automatic w_ien(input logic v);
    @(negedge clk); #1; ien_we = 1; ien_wd = v;
    @(negedge clk); #1; ien_we = 0;
  endtask
  task automatic w_ist(input logic v);
    @(negedge clk); #1; ist_we = 1; ist_wd = v;
    @(negedge clk); #1; ist_we = 0;
  endtask
  task automatic w_itst(input logic v);
    @(negedge clk); #1; itst_we = 1; itst_wd = v;
    @(negedge clk); #1; itst_we = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    #1; rst_n = 1;
    live = 1;
    idle(3);
    chk("R1", cfg_rd, 32'h0001_0000);
    chk("R1", cnt_lo_rd, 0);
    chk("R1", cmp_lo_rd, 32'hFFFF_FFFF);
    chk("R1", cmp_hi_rd, 32'hFFFF_FFFF);
    chk("R1", irq_o, 0);

    // R6: field layout and zero gaps
    cur_req = "R6";
    w_cfg(32'hFFFF_FFFF);
    chk("R6", cfg_rd, 32'h00FF_0FFF);
    w_cfg(32'h0001_0000);

    // R2: inactive count holds
    cur_req = "R2";
    w_cnt(0, 32'd5);
    idle(10);
    chk("R2", cnt_lo_rd, 5);

    // R3: tick rates
    cur_req = "R3";
    w_run(1);
    idle(8);
    w_cfg(32'h0005_0003);
    idle(24);
    w_run(0);
    idle(4);
    w_run(1);
    idle(10);

    // R4: wide step and 64-bit wrap
    cur_req = "R4";
    w_cfg(32'h0080_0000);
    w_cnt(1, 32'hFFFF_FFFF);
    w_cnt(0, 32'hFFFF_FF00);
    idle(6);

    // R5: write over a tick
    cur_req = "R5";
    w_cfg(32'h0001_0000);
    w_cnt(0, 32'h0000_0100);
    chk("R5", cnt_lo_rd, 32'h0000_0100);
    idle(3);

    // R12: halves read back
    cur_req = "R12";
    w_run(0);
    w_cnt(1, 32'h1234_5678);
    chk("R12", cnt_hi_rd, 32'h1234_5678);
    w_cmp(1, 32'h0000_0000);
    chk("R12", cmp_hi_rd, 0);

    // R7 / R8: compare reload and event
    cur_req = "R7";
    w_cnt(1, 0);
    w_cnt(0, 0);
    w_cmp(0, 32'h40);
    w_ien(1);
    w_cfg(32'h0004_0001);
    cur_req = "R8";
    w_run(1);
    idle(40);
    chk("R8", ist_rd, 1);
    chk("R11", irq_o, 1);

    // R9: clear while still reached re-sets; zero write no effect
    cur_req = "R9";
    w_ist(1);
    idle(2);
    w_run(0);
    w_cmp(0, 32'hFFFF_FFFF);
    w_cmp(1, 32'hFFFF_FFFF);
    idle(4);
    w_ist(1);
    idle(2);
    chk("R9", ist_rd, 0);
    w_itst(1);
    w_ist(0);
    chk("R9", ist_rd, 1);
    w_ist(1);
    chk("R9", ist_rd, 0);

    // R10: test register
    cur_req = "R10";
    w_itst(1);
    chk("R10", ist_rd, 1);
    chk("R10", itst_rd, 0);
    w_ist(1);

    // R11: masking
    cur_req = "R11";
    w_ien(0);
    w_itst(1);
    chk("R11", irq_o, 0);
    chk("R11", ist_rd, 1);
    w_ien(1);
    chk("R11", irq_o, 1);
    idle(3);

    finish_run();
  end
endmodule